// File: doc/BRIEF.md
# DRAM direct command issuer

This block lets software drive an SDRAM controller's command bus by hand. Software writes a 32-bit command word. The word names a command type, a target chip, a bank and an address. The block holds the word until the scheduler reports that the command queue for that chip is empty. It then either emits a single command/address cycle or drops the word as illegal.

For each chip the block keeps two pieces of state: a power state and a mask of open banks. The main scheduler reports each bank activation on a notification input, which feeds the open-bank mask. The block refuses any command that is not legal in the chip's current state. A refused command produces no bus cycle and sets a sticky error flag.

For mode-register write and read, the block repacks the bank and address fields into the 8-bit register-address and opcode fields that LPDDR2 devices expect. A mode-register read returns one byte. The block captures that byte from the read-data input after a fixed latency and presents it with a one-cycle valid pulse.

Top module: `dram_dcmd_issuer`

## Requirements
- R1: After reset, busy_o, err_o, ca_valid_o and mrr_valid_o are 0, and every chip reports state IDLE.
- R2: The command word is laid out as follows:
  - type in bits 27:24;
  - chip in bit 20;
  - bank in bits 18:16;
  - address in bits 14:0.

  A word presented with cmd_valid_i while busy_o is 0 is accepted, and busy_o rises on the next cycle. An accepted legal command drives ca_valid_o for exactly one cycle. During that cycle ca_cs_o is one-hot for the chip, ca_cmd_o carries the type, and ca_bank_o and ca_addr_o carry the bank and address fields. busy_o is 0 on the cycle after.
- R3: A held command does not issue while queue_empty_i for its target chip is 0. The state of the other chip's queue has no effect on it.
- R4: A word is dropped with no bus cycle, and err_o is set, in either case:
  - any bit in 31:28, 23:21, 19 or 15 is 1;
  - the type is 10 to 15.
- R5: Mode register set (type 0) and mode register read (type 9) are refused while the target chip has any open bank or is in a low-power state.
- R6: For every issued command, mr_addr_o equals {addr[1:0], bank[2:0], addr[12:10]} and mr_op_o equals addr[9:2].
- R7: Power-down entry (type 6) is legal from IDLE and from ACTIVE, and moves the chip to POWER_DOWN. In POWER_DOWN only NOP (type 7) is accepted. NOP returns the chip to IDLE or ACTIVE, according to its open banks.
- R8: Self refresh entry (type 4) is legal only from IDLE and moves the chip to SELF_REFRESH. In SELF_REFRESH only self-refresh exit (type 8) is accepted, and it returns the chip to IDLE. Type 8 is refused in every other state.
- R9: Deep power down (type 3) and auto refresh (type 5) are legal only from IDLE. Deep power down moves the chip to DEEP_POWER_DOWN, where only NOP is accepted. NOP returns the chip to IDLE.
- R10: Bank tracking works as follows:
  - precharge-one (type 2) closes the named bank;
  - precharge-all (type 1) closes every bank;
  - a chip with no open bank reports IDLE.

  The state codes on chip_state_o are IDLE 0, ACTIVE 1, POWER_DOWN 2, SELF_REFRESH 3 and DEEP_POWER_DOWN 4, with 3 bits per chip.
- R11: MRR_LAT cycles after an issued mode register read's ca_valid_o cycle, mrr_valid_o pulses for one cycle. mrr_data_o then holds the rd_data_i value sampled at that edge.
- R12: err_o stays 1 until reset, whatever commands follow.
- R13: cmd_valid_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 32 | Command word |
| queue_empty_i | input | NUM_CHIPS | Per-chip command queue empty |
| act_valid_i | input | 1 | Scheduler opened a bank |
| act_chip_i | input | CHIP_W | Chip of the activation |
| act_bank_i | input | BANK_W | Bank of the activation |
| rd_data_i | input | RD_W | Mode-register read data |
| busy_o | output | 1 | Command held or being issued |
| err_o | output | 1 | Sticky refused-command flag |
| ca_valid_o | output | 1 | Command cycle strobe |
| ca_cs_o | output | NUM_CHIPS | One-hot chip select |
| ca_cmd_o | output | 4 | Command code |
| ca_bank_o | output | BANK_W | Bank |
| ca_addr_o | output | ADDR_W | Address |
| mr_addr_o | output | 8 | LPDDR2 mode-register address |
| mr_op_o | output | 8 | LPDDR2 mode-register opcode |
| mrr_valid_o | output | 1 | Read data strobe |
| mrr_data_o | output | RD_W | Captured read data |
| chip_state_o | output | 3*NUM_CHIPS | Per-chip state code |

## Verification
The assertions assume two things about the inputs. First, an activation notice never coincides with a precharge-all to the same chip. Second, rd_data_i is stable around its capture edge. The bench meets both assumptions: it issues activations only between commands, on a cycle of their own, and it holds rd_data_i constant across each read. The bench also drives queue_empty_i only at negative edges, so the issue cycle is never ambiguous.

// File: rtl/dram_dcmd_pkg.sv
package dram_dcmd_pkg;
  localparam int TYPE_LSB = 24;
  localparam int CHIP_LSB = 20;
  localparam int CHIP_W   = 1;
  localparam int BANK_LSB = 16;
  localparam int BANK_W   = 3;
  localparam int ADDR_W   = 15;
  localparam int NUM_CHIPS = 1 << CHIP_W;
  localparam int ST_W     = 3;
  localparam logic [31:0] RSVD_MASK = 32'hF0E8_8000;

  typedef enum logic [3:0] {
    CMD_MRS  = 4'd0,
    CMD_PALL = 4'd1,
    CMD_PRE  = 4'd2,
    CMD_DPD  = 4'd3,
    CMD_REFS = 4'd4,
    CMD_REFA = 4'd5,
    CMD_PDE  = 4'd6,
    CMD_NOP  = 4'd7,
    CMD_SRX  = 4'd8,
    CMD_MRR  = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PD     = 3'd2,
    ST_SR     = 3'd3,
    ST_DPD    = 3'd4
  } chip_st_e;

  typedef enum logic [1:0] {PW_ON, PW_PD, PW_SR, PW_DPD} pwr_e;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_DONE} phase_e;
endpackage

// File: rtl/dram_dcmd_decode.sv
module dram_dcmd_decode
  import dram_dcmd_pkg::*;
(
  input  logic [31:0]        word_i,
  output logic [3:0]         typ_o,
  output logic [CHIP_W-1:0]  chip_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [7:0]         mr_addr_o,
  output logic [7:0]         mr_op_o,
  output logic               fmt_bad_o
);
  assign typ_o     = word_i[TYPE_LSB +: 4];
  assign chip_o    = word_i[CHIP_LSB +: CHIP_W];
  assign bank_o    = word_i[BANK_LSB +: BANK_W];
  assign addr_o    = word_i[ADDR_W-1:0];
  // LPDDR2 mode-register packing
  assign mr_addr_o = {addr_o[1:0], bank_o, addr_o[12:10]};
  assign mr_op_o   = addr_o[9:2];
  assign fmt_bad_o = ((word_i & RSVD_MASK) != '0) || (typ_o > CMD_MRR);
endmodule

// File: rtl/dram_dcmd_chip.sv
module dram_dcmd_chip
  import dram_dcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [3:0]        typ_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  output logic              legal_o,
  output logic [ST_W-1:0]   state_o
);
  localparam int NB = 1 << BANK_W;

  pwr_e          pwr_q, pwr_n;
  logic [NB-1:0] open_q, open_n;
  logic          idle;

  assign idle = (open_q == '0);

  always_comb begin
    legal_o = 1'b0;
    unique case (pwr_q)
      PW_ON: begin
        case (typ_i)
          CMD_MRS, CMD_MRR, CMD_DPD, CMD_REFS, CMD_REFA: legal_o = idle;
          CMD_PALL, CMD_PRE, CMD_PDE, CMD_NOP:           legal_o = 1'b1;
          default:                                       legal_o = 1'b0;
        endcase
      end
      PW_PD, PW_DPD: legal_o = (typ_i == CMD_NOP);
      PW_SR:         legal_o = (typ_i == CMD_SRX);
    endcase
  end

  always_comb begin
    pwr_n  = pwr_q;
    open_n = open_q;
    if (issue_i) begin
      if (pwr_q == PW_ON) begin
        case (typ_i)
          CMD_PALL: open_n = '0;
          CMD_PRE:  open_n[bank_i] = 1'b0;
          CMD_DPD:  pwr_n = PW_DPD;
          CMD_REFS: pwr_n = PW_SR;
          CMD_PDE:  pwr_n = PW_PD;
          default:  ;
        endcase
      end else begin
        pwr_n = PW_ON;
      end
    end
    // activations count only while the chip is awake
    if (act_i && pwr_n == PW_ON) open_n[act_bank_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= PW_ON;
      open_q <= '0;
    end else begin
      pwr_q  <= pwr_n;
      open_q <= open_n;
    end
  end

  always_comb begin
    unique case (pwr_q)
      PW_ON:  state_o = idle ? ST_IDLE : ST_ACTIVE;
      PW_PD:  state_o = ST_PD;
      PW_SR:  state_o = ST_SR;
      PW_DPD: state_o = ST_DPD;
    endcase
  end

  assert_issue_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> legal_o);
  assert_mr_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && (typ_i == CMD_MRS || typ_i == CMD_MRR)) |-> (open_q == '0 && pwr_q == PW_ON));
  assert_pd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q == PW_PD && !(issue_i && typ_i == CMD_NOP)) |=> pwr_q == PW_PD);
  assert_sr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q == PW_SR && !(issue_i && typ_i == CMD_SRX)) |=> pwr_q == PW_SR);
  assert_dpd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && typ_i == CMD_DPD) |-> open_q == '0);
  assert_pall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && typ_i == CMD_PALL && !act_i) |=> open_q == '0);
endmodule

// File: rtl/dram_dcmd_mrr.sv
module dram_dcmd_mrr #(
  parameter int LAT  = 4,
  parameter int RD_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [RD_W-1:0] rd_data_i,
  output logic            valid_o,
  output logic [RD_W-1:0] data_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        cnt_q <= CW'(LAT);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          valid_o <= 1'b1;
          data_o  <= rd_data_i;
        end
      end
    end
  end

  assert_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/dram_dcmd_issuer.sv
module dram_dcmd_issuer
  import dram_dcmd_pkg::*;
#(
  parameter int MRR_LAT = 4,
  parameter int RD_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [31:0]               cmd_word_i,
  input  logic [NUM_CHIPS-1:0]      queue_empty_i,
  input  logic                      act_valid_i,
  input  logic [CHIP_W-1:0]         act_chip_i,
  input  logic [BANK_W-1:0]         act_bank_i,
  input  logic [RD_W-1:0]           rd_data_i,
  output logic                      busy_o,
  output logic                      err_o,
  output logic                      ca_valid_o,
  output logic [NUM_CHIPS-1:0]      ca_cs_o,
  output logic [3:0]                ca_cmd_o,
  output logic [BANK_W-1:0]         ca_bank_o,
  output logic [ADDR_W-1:0]         ca_addr_o,
  output logic [7:0]                mr_addr_o,
  output logic [7:0]                mr_op_o,
  output logic                      mrr_valid_o,
  output logic [RD_W-1:0]           mrr_data_o,
  output logic [NUM_CHIPS*ST_W-1:0] chip_state_o
);
  phase_e              phase_q;
  logic [31:0]         word_q;
  logic [3:0]          typ;
  logic [CHIP_W-1:0]   chip;
  logic [BANK_W-1:0]   bank;
  logic [ADDR_W-1:0]   addr;
  logic [7:0]          mr_addr, mr_op;
  logic                fmt_bad;
  logic [NUM_CHIPS-1:0] legal_vec, cs_dec;
  logic                legal, go, issue;

  dram_dcmd_decode u_decode (
    .word_i    (word_q),
    .typ_o     (typ),
    .chip_o    (chip),
    .bank_o    (bank),
    .addr_o    (addr),
    .mr_addr_o (mr_addr),
    .mr_op_o   (mr_op),
    .fmt_bad_o (fmt_bad)
  );

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    dram_dcmd_chip u_chip (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue && chip == CHIP_W'(c)),
      .typ_i      (typ),
      .bank_i     (bank),
      .act_i      (act_valid_i && act_chip_i == CHIP_W'(c)),
      .act_bank_i (act_bank_i),
      .legal_o    (legal_vec[c]),
      .state_o    (chip_state_o[c*ST_W +: ST_W])
    );
  end

  always_comb begin
    cs_dec       = '0;
    cs_dec[chip] = 1'b1;
  end

  assign legal  = legal_vec[chip] && !fmt_bad;
  assign go     = (phase_q == PH_WAIT) && queue_empty_i[chip];
  assign issue  = go && legal;
  assign busy_o = (phase_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      word_q     <= '0;
      err_o      <= 1'b0;
      ca_valid_o <= 1'b0;
      ca_cs_o    <= '0;
      ca_cmd_o   <= '0;
      ca_bank_o  <= '0;
      ca_addr_o  <= '0;
      mr_addr_o  <= '0;
      mr_op_o    <= '0;
    end else begin
      ca_valid_o <= issue;
      ca_cs_o    <= issue ? cs_dec : '0;
      unique case (phase_q)
        PH_IDLE: if (cmd_valid_i) begin
          word_q  <= cmd_word_i;
          phase_q <= PH_WAIT;
        end
        PH_WAIT: if (go) phase_q <= PH_DONE;
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
      if (go && !legal) err_o <= 1'b1;
      if (issue) begin
        ca_cmd_o  <= typ;
        ca_bank_o <= bank;
        ca_addr_o <= addr;
        mr_addr_o <= mr_addr;
        mr_op_o   <= mr_op;
      end
    end
  end

  dram_dcmd_mrr #(.LAT(MRR_LAT), .RD_W(RD_W)) u_mrr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (issue && typ == CMD_MRR),
    .rd_data_i (rd_data_i),
    .valid_o   (mrr_valid_o),
    .data_o    (mrr_data_o)
  );

  assert_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_valid_o |=> !ca_valid_o);
  assert_busy_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_valid_o |=> !busy_o);
  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_valid_o |-> $countones(ca_cs_o) == 1);
  assert_queue_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ca_valid_o |-> ($past(queue_empty_i) & ca_cs_o) != '0);
  assert_err_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_ignore_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && phase_q != PH_DONE) |=> $stable(word_q));
endmodule

// File: tb/dram_dcmd_issuer_bench.sv
module dram_dcmd_issuer_bench;
  localparam int LAT = 4;
  localparam int NV  = 30;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0]  q_empty = 2'b11;
  logic        act_valid = 1'b0, act_chip = 1'b0;
  logic [2:0]  act_bank = '0;
  logic [7:0]  rd_data = '0;
  logic        busy_o, err_o, ca_valid_o, mrr_valid_o;
  logic [1:0]  ca_cs_o;
  logic [3:0]  ca_cmd_o;
  logic [2:0]  ca_bank_o;
  logic [14:0] ca_addr_o;
  logic [7:0]  mr_addr_o, mr_op_o, mrr_data_o;
  logic [5:0]  chip_state_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic        s_seen;
  logic [3:0]  s_cmd;
  logic [1:0]  s_cs;
  logic [2:0]  s_bank;
  logic [14:0] s_addr;
  logic [7:0]  s_ma, s_op;

  dram_dcmd_issuer #(.MRR_LAT(LAT), .RD_W(8)) u_dram_dcmd_issuer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .queue_empty_i(q_empty), .act_valid_i(act_valid), .act_chip_i(act_chip),
    .act_bank_i(act_bank), .rd_data_i(rd_data), .busy_o(busy_o), .err_o(err_o),
    .ca_valid_o(ca_valid_o), .ca_cs_o(ca_cs_o), .ca_cmd_o(ca_cmd_o),
    .ca_bank_o(ca_bank_o), .ca_addr_o(ca_addr_o), .mr_addr_o(mr_addr_o),
    .mr_op_o(mr_op_o), .mrr_valid_o(mrr_valid_o), .mrr_data_o(mrr_data_o),
    .chip_state_o(chip_state_o)
  );

  always #4ns clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // {act, act_bank, word, expect_issue, expect_state_chip0}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 3'd0, 32'h0800_0000, 1'b0, 3'd0},
    {1'b1, 3'd2, 32'h0700_0000, 1'b1, 3'd1},
    {1'b0, 3'd0, 32'h0000_0400, 1'b0, 3'd1},
    {1'b0, 3'd0, 32'h0900_0000, 1'b0, 3'd1},
    {1'b0, 3'd0, 32'h0400_0000, 1'b0, 3'd1},
    {1'b0, 3'd0, 32'h0300_0000, 1'b0, 3'd1},
    {1'b0, 3'd0, 32'h0500_0000, 1'b0, 3'd1},
    {1'b0, 3'd0, 32'h0600_0000, 1'b1, 3'd2},
    {1'b0, 3'd0, 32'h0800_0000, 1'b0, 3'd2},
    {1'b0, 3'd0, 32'h0000_0000, 1'b0, 3'd2},
    {1'b0, 3'd0, 32'h0700_0000, 1'b1, 3'd1},
    {1'b0, 3'd0, 32'h0202_0000, 1'b1, 3'd0},
    {1'b0, 3'd0, 32'h0600_0000, 1'b1, 3'd2},
    {1'b0, 3'd0, 32'h0700_0000, 1'b1, 3'd0},
    {1'b0, 3'd0, 32'h0400_0000, 1'b1, 3'd3},
    {1'b0, 3'd0, 32'h0700_0000, 1'b0, 3'd3},
    {1'b0, 3'd0, 32'h0500_0000, 1'b0, 3'd3},
    {1'b0, 3'd0, 32'h0800_0000, 1'b1, 3'd0},
    {1'b0, 3'd0, 32'h0300_0000, 1'b1, 3'd4},
    {1'b0, 3'd0, 32'h0800_0000, 1'b0, 3'd4},
    {1'b0, 3'd0, 32'h0600_0000, 1'b0, 3'd4},
    {1'b0, 3'd0, 32'h0700_0000, 1'b1, 3'd0},
    {1'b1, 3'd1, 32'h0205_0000, 1'b1, 3'd1},
    {1'b1, 3'd5, 32'h0100_0000, 1'b1, 3'd0},
    {1'b0, 3'd0, 32'h0500_0000, 1'b1, 3'd0},
    {1'b0, 3'd0, 32'h0A00_0000, 1'b0, 3'd0},
    {1'b0, 3'd0, 32'h0F00_0000, 1'b0, 3'd0},
    {1'b0, 3'd0, 32'h0003_1234, 1'b1, 3'd0},
    {1'b1, 3'd0, 32'h8700_0000, 1'b0, 3'd1},
    {1'b0, 3'd0, 32'h0100_0000, 1'b1, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [31:0] w);
    if ((w & 32'hF0E8_8000) != 0 || w[27:24] > 4'd9) return "R4";
    case (w[27:24])
      4'd0, 4'd9: return "R5";
      4'd6, 4'd7: return "R7";
      4'd4, 4'd8: return "R8";
      4'd3, 4'd5: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    while (busy_o) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_seen = 1'b0;
    while (busy_o) begin
      if (ca_valid_o) begin
        s_seen = 1'b1; s_cmd = ca_cmd_o; s_cs = ca_cs_o; s_bank = ca_bank_o;
        s_addr = ca_addr_o; s_ma = mr_addr_o; s_op = mr_op_o;
      end
      @(negedge clk);
    end
  endtask

  task automatic act(input logic c, input logic [2:0] b);
    act_chip = c; act_bank = b; act_valid = 1'b1;
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", busy_o, 0, "busy");
    chk("R1", err_o, 0, "err");
    chk("R1", ca_valid_o, 0, "ca_valid");
    chk("R1", mrr_valid_o, 0, "mrr_valid");
    chk("R1", chip_state_o, 0, "chip_state");

    // vector walk on chip 0: R4 R5 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      if (v[39]) act(1'b0, v[38:36]);
      send(v[35:4]);
      chk(tag_of(v[35:4]), s_seen, v[3], $sformatf("vec %0d issue", i));
      chk(tag_of(v[35:4]), chip_state_o[2:0], v[2:0], $sformatf("vec %0d state", i));
      if (v[3] && s_seen) begin
        chk("R2", s_cmd, v[31:28], $sformatf("vec %0d cmd", i));
        chk("R2", s_cs, 2'b01, $sformatf("vec %0d cs", i));
        chk("R2", s_bank, v[22:20], $sformatf("vec %0d bank", i));
        chk("R2", s_addr, v[18:4], $sformatf("vec %0d addr", i));
      end
      if (i == 0) chk("R12", err_o, 1, "err after first refusal");
      chk("R2", busy_o, 0, $sformatf("vec %0d busy cleared", i));
    end
    chk("R12", err_o, 1, "err held after legal commands");

    // R3 blocked queue, R13 ignored while busy
    q_empty   = 2'b01;
    cmd_valid = 1'b1; cmd_word = 32'h0710_0000;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_seen = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (ca_valid_o) s_seen = 1'b1;
      if (k == 2) begin cmd_valid = 1'b1; cmd_word = 32'h0410_0000; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R3", s_seen, 0, "no issue while queue busy");
    chk("R3", busy_o, 1, "held busy");
    q_empty = 2'b11;
    while (busy_o) begin
      if (ca_valid_o) begin s_seen = 1'b1; s_cmd = ca_cmd_o; s_cs = ca_cs_o; end
      @(negedge clk);
    end
    chk("R3", s_seen, 1, "issue after queue empty");
    chk("R13", s_cmd, 4'd7, "held command kept");
    chk("R2", s_cs, 2'b10, "chip1 select");
    repeat (3) @(negedge clk);
    chk("R13", ca_valid_o, 0, "no second issue");
    chk("R13", chip_state_o[5:3], 3'd0, "chip1 not in self refresh");

    // R6 LPDDR2 packing, chip 1 bank 5 addr 1ABD
    send(32'h0015_1ABD);
    begin
      logic [14:0] a;
      a = 15'h1ABD;
      chk("R6", s_seen, 1, "mrs issued");
      chk("R6", s_ma, {a[1:0], 3'd5, a[12:10]}, "mr addr");
      chk("R6", s_ma, 8'h6E, "mr addr literal");
      chk("R6", s_op, a[9:2], "mr op");
      chk("R6", s_op, 8'hAF, "mr op literal");
    end

    // R11 mode register read latency and data
    rd_data = 8'h5C;
    send(32'h0910_0000);
    chk("R11", s_seen, 1, "mrr issued");
    begin
      int k;
      k = 1;
      while (!mrr_valid_o && k < 20) begin @(negedge clk); k++; end
      chk("R11", k, LAT, "latency");
      chk("R11", mrr_data_o, 8'h5C, "data");
      @(negedge clk);
      chk("R11", mrr_valid_o, 0, "single pulse");
    end

    // R12 cleared only by reset
    do_reset();
    chk("R12", err_o, 0, "err after reset");
    chk("R1", chip_state_o, 0, "state after reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule